// File: doc/BRIEF.md
# Access Permission Evaluator

This block decides, for one memory access, which rights the matched translation entry grants and which fault (if any) the access raises. It is fed with the kind of access, the current privilege level, whether address translation is on, whether protection-identifier checking is on, a bank of protection-identifier registers and the fields of the entry that matched the virtual address. It returns a three-bit rights mask and a four-bit fault code one clock after a request strobe, along with a result-valid strobe.

The evaluation runs in a fixed order. Translation off and a missing entry short-circuit everything else. The entry's privilege bounds and rights type then give a base mask. A protection-identifier match may strip write permission. Internal probes with no architectural access kind stop there. Finally the rights test and the dirty, break and reference-trap bits are applied, with each later condition replacing the fault code chosen by an earlier one.

Top module: `prot_check_unit`

## Requirements
- R1: When `xlate_en` is 0 the result is rights 3'b111 and fault 0, whatever the entry fields hold.
- R2: With translation on and `ent_valid` 0, rights are 0 and the fault is 1 (instruction miss) for kind 3 (execute), and 2 (data miss) for kind 0, 1 or 2 (none, read, write).
- R3: Privileges are numbered with 0 most privileged. Read right (rights bit 0) needs priv <= `ent_rd_pl`, write right (bit 1) needs priv <= `ent_wr_pl`, execute right (bit 2) needs `ent_wr_pl` <= priv <= `ent_rd_pl`.
- R4: `ent_rtype` selects which of those rights can be granted: 0 read, 1 read and write, 2 read and execute, 3 all three, 4 to 7 execute only.
- R5: With `pid_chk_en` 1 and a nonzero `ent_aid`, the value `ent_aid`*2+1 is compared with every protection-identifier register. On any equality write is cleared from the mask, and a write access (kind 2) ends evaluation with fault 3. An `ent_aid` of 0 or `pid_chk_en` 0 skips the comparison.
- R6: When the requested right is not in the mask, the fault is 4 for execute and 5 for read or write.
- R7: With `ent_dirty` 0, write is cleared from the mask and a write access gets fault 6.
- R8: With `ent_brk` 1, write is cleared from the mask and a write access gets fault 7, replacing fault 6.
- R9: With `ent_trap` 1, only execute stays in the mask and a read or write access gets fault 8, replacing faults 6 and 7; execute gets no fault from it.
- R10: An access of kind 0 (none) with a valid entry returns the mask after the protection-identifier step, fault 0, and skips the R6 to R9 checks.
- R11: `res_valid` is 1 exactly in the cycle after a clock edge that sampled `req_valid` at 1; the result registers update only on such edges and otherwise hold their value; reset clears them and `res_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; inputs are sampled on this edge |
| acc_kind | input | 2 | 0 none, 1 read, 2 write, 3 execute |
| priv | input | 2 | Current privilege level |
| xlate_en | input | 1 | Address translation enabled |
| pid_chk_en | input | 1 | Protection-identifier check enabled |
| pid_regs | input | NUM_PID*PID_W | Protection-identifier registers, register k in bits [k*PID_W +: PID_W] |
| ent_valid | input | 1 | Matched entry exists and is valid |
| ent_aid | input | AID_W | Entry access identifier |
| ent_rd_pl | input | 2 | Entry read privilege bound |
| ent_wr_pl | input | 2 | Entry write privilege bound |
| ent_rtype | input | 3 | Entry rights type |
| ent_brk | input | 1 | Entry break bit |
| ent_dirty | input | 1 | Entry dirty bit |
| ent_trap | input | 1 | Entry reference-trap bit |
| res_valid | output | 1 | Result strobe |
| res_rights | output | 3 | Granted rights: bit 0 read, bit 1 write, bit 2 execute |
| res_fault | output | 4 | Fault code, 0 for none |

## Verification
The hardest situation to reach is a write whose entry has the dirty bit clear, the break bit set and the trap bit set at once, because only the last applied condition may show in the fault code and an error in ordering only appears when several conditions overlap. The stimulus builds these overlaps step by step from an entry that grants every right at privilege 0, so the rights test passes and the later checks decide the code. A similar layering is used for the identifier match, where a write must stop at the identifier fault even though a clear dirty bit would otherwise apply.

// File: rtl/prot_pkg.sv
// Shared types for the access permission evaluator.
// Assumes a three-bit rights mask and a four-bit fault code.
package prot_pkg;

    localparam int PL_W     = 2;
    localparam int RIGHTS_W = 3;
    localparam int RTYPE_W  = 3;
    localparam int FAULT_W  = 4;

    localparam int RIGHT_R = 0;
    localparam int RIGHT_W = 1;
    localparam int RIGHT_X = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_kind_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE    = 4'd0,
        FLT_IMISS   = 4'd1,
        FLT_DMISS   = 4'd2,
        FLT_PID     = 4'd3,
        FLT_IPROT   = 4'd4,
        FLT_DRIGHTS = 4'd5,
        FLT_DIRTY   = 4'd6,
        FLT_BREAK   = 4'd7,
        FLT_PAGEREF = 4'd8
    } fault_e;

    // Rights bit requested by an access kind; empty for ACC_NONE.
    function automatic logic [RIGHTS_W-1:0] kind_mask(acc_kind_e k);
        logic [RIGHTS_W-1:0] m;
        m = '0;
        case (k)
            ACC_READ:  m[RIGHT_R] = 1'b1;
            ACC_WRITE: m[RIGHT_W] = 1'b1;
            ACC_EXEC:  m[RIGHT_X] = 1'b1;
            default:   m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/prot_rights_base.sv
// Base rights from privilege bounds and the entry's rights type.
// Assumes lower privilege numbers mean more privilege.
module prot_rights_base
    import prot_pkg::*;
(
    input  logic [PL_W-1:0]     priv,
    input  logic [PL_W-1:0]     rd_pl,
    input  logic [PL_W-1:0]     wr_pl,
    input  logic [RTYPE_W-1:0]  rtype,
    output logic [RIGHTS_W-1:0] rights
);

    logic can_r, can_w, can_x;

    // Privilege-bound tests for each right.
    always_comb begin
        can_r = (priv <= rd_pl);
        can_w = (priv <= wr_pl);
        can_x = (wr_pl <= priv) && (priv <= rd_pl);
    end

    // Rights type selects which tested rights are offered.
    always_comb begin
        rights = '0;
        case (rtype)
            3'd0: rights[RIGHT_R] = can_r;
            3'd1: begin
                rights[RIGHT_R] = can_r;
                rights[RIGHT_W] = can_w;
            end
            3'd2: begin
                rights[RIGHT_R] = can_r;
                rights[RIGHT_X] = can_x;
            end
            3'd3: begin
                rights[RIGHT_R] = can_r;
                rights[RIGHT_W] = can_w;
                rights[RIGHT_X] = can_x;
            end
            default: rights[RIGHT_X] = can_x;
        endcase
    end

endmodule

// File: rtl/prot_pid_match.sv
// Compares the entry's identifier key against every protection-ID register.
// Assumes PID_W > AID_W; the key is aid*2+1 zero-extended to PID_W bits.
module prot_pid_match #(
    parameter int AID_W   = 15,
    parameter int PID_W   = 16,
    parameter int NUM_PID = 4
) (
    input  logic                     chk_en,
    input  logic [AID_W-1:0]         aid,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    output logic                     hit
);

    logic [PID_W-1:0]   key;
    logic [NUM_PID-1:0] eq;

    // Build the comparison key from the access identifier.
    always_comb begin
        key = '0;
        key[AID_W:0] = {aid, 1'b1};
    end

    // One comparator per protection-ID register.
    for (genvar k = 0; k < NUM_PID; k++) begin : g_cmp
        assign eq[k] = (pid_regs[k*PID_W +: PID_W] == key);
    end

    // A zero identifier marks a public page: never matches.
    assign hit = chk_en && (aid != '0) && (|eq);

endmodule

// File: rtl/prot_fault_chain.sv
// Ordered fault evaluation: bypass, miss, identifier, probe, rights,
// then dirty, break and trap with later codes replacing earlier ones.
module prot_fault_chain
    import prot_pkg::*;
(
    input  logic                xlate_en,
    input  logic                ent_valid,
    input  acc_kind_e           kind,
    input  logic [RIGHTS_W-1:0] base_rights,
    input  logic                pid_hit,
    input  logic                brk,
    input  logic                dirty,
    input  logic                trap,
    output logic [RIGHTS_W-1:0] rights,
    output fault_e              fault
);

    logic is_exec, is_write;
    assign is_exec  = (kind == ACC_EXEC);
    assign is_write = (kind == ACC_WRITE);

    // Walk the checks in order, stopping early where a step is final.
    always_comb begin
        rights = base_rights;
        fault  = FLT_NONE;
        if (!xlate_en) begin
            rights = '1;
        end else if (!ent_valid) begin
            rights = '0;
            fault  = is_exec ? FLT_IMISS : FLT_DMISS;
        end else begin
            if (pid_hit) begin
                rights[RIGHT_W] = 1'b0;
            end
            if (pid_hit && is_write) begin
                fault = FLT_PID;
            end else if (kind == ACC_NONE) begin
                fault = FLT_NONE;
            end else if ((rights & kind_mask(kind)) == '0) begin
                fault = is_exec ? FLT_IPROT : FLT_DRIGHTS;
            end else begin
                if (!dirty) begin
                    rights[RIGHT_W] = 1'b0;
                    if (is_write) fault = FLT_DIRTY;
                end
                if (brk) begin
                    rights[RIGHT_W] = 1'b0;
                    if (is_write) fault = FLT_BREAK;
                end
                if (trap) begin
                    rights[RIGHT_R] = 1'b0;
                    rights[RIGHT_W] = 1'b0;
                    if (!is_exec) fault = FLT_PAGEREF;
                end
            end
        end
    end

endmodule

// File: rtl/prot_check_unit.sv
// Top of the access permission evaluator: combinational evaluation of one
// access, registered with a one-cycle result strobe.
// Assumes all inputs are stable at the edge that samples req_valid.
module prot_check_unit
    import prot_pkg::*;
#(
    parameter int AID_W   = 15,
    parameter int PID_W   = 16,
    parameter int NUM_PID = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               acc_kind,
    input  logic [1:0]               priv,
    input  logic                     xlate_en,
    input  logic                     pid_chk_en,
    input  logic [NUM_PID*PID_W-1:0] pid_regs,
    input  logic                     ent_valid,
    input  logic [AID_W-1:0]         ent_aid,
    input  logic [1:0]               ent_rd_pl,
    input  logic [1:0]               ent_wr_pl,
    input  logic [2:0]               ent_rtype,
    input  logic                     ent_brk,
    input  logic                     ent_dirty,
    input  logic                     ent_trap,
    output logic                     res_valid,
    output logic [2:0]               res_rights,
    output logic [3:0]               res_fault
);

    acc_kind_e           kind;
    logic [RIGHTS_W-1:0] base_rights;
    logic                pid_hit;
    logic [RIGHTS_W-1:0] nxt_rights;
    fault_e              nxt_fault;

    assign kind = acc_kind_e'(acc_kind);

    prot_rights_base u_base (
        .priv   (priv),
        .rd_pl  (ent_rd_pl),
        .wr_pl  (ent_wr_pl),
        .rtype  (ent_rtype),
        .rights (base_rights)
    );

    prot_pid_match #(
        .AID_W   (AID_W),
        .PID_W   (PID_W),
        .NUM_PID (NUM_PID)
    ) u_pid (
        .chk_en   (pid_chk_en),
        .aid      (ent_aid),
        .pid_regs (pid_regs),
        .hit      (pid_hit)
    );

    prot_fault_chain u_chain (
        .xlate_en    (xlate_en),
        .ent_valid   (ent_valid),
        .kind        (kind),
        .base_rights (base_rights),
        .pid_hit     (pid_hit),
        .brk         (ent_brk),
        .dirty       (ent_dirty),
        .trap        (ent_trap),
        .rights      (nxt_rights),
        .fault       (nxt_fault)
    );

    // Result strobe follows the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= req_valid;
    end

    // Capture the evaluation on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_rights <= '0;
            res_fault  <= '0;
        end else if (req_valid) begin
            res_rights <= nxt_rights;
            res_fault  <= nxt_fault;
        end
    end

    // R1
    xlate_off_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !xlate_en |=> res_rights == 3'b111 && res_fault == FLT_NONE);

    // R2
    miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && xlate_en && !ent_valid |=> res_rights == 3'b000 &&
        (res_fault == FLT_IMISS || res_fault == FLT_DMISS));

    // R5
    pid_fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault == FLT_PID |-> !res_rights[RIGHT_W]);

    // R9
    pageref_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault == FLT_PAGEREF |-> !res_rights[RIGHT_R] && !res_rights[RIGHT_W]);

    // R10
    probe_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && xlate_en && ent_valid && acc_kind == 2'd0 |=> res_fault == FLT_NONE);

    // R11
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && $stable(res_rights) && $stable(res_fault));

endmodule

// File: tb/tb_prot_check_unit.sv
module tb_prot_check_unit;

    localparam int AID_W = 15;
    localparam int PID_W = 16;
    localparam int NPID  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] acc_kind = 2'd0;
    logic [1:0] priv = 2'd0;
    logic xlate_en = 1'b1;
    logic pid_chk_en = 1'b0;
    logic [NPID*PID_W-1:0] pid_regs = '0;
    logic ent_valid = 1'b1;
    logic [AID_W-1:0] ent_aid = '0;
    logic [1:0] ent_rd_pl = 2'd3;
    logic [1:0] ent_wr_pl = 2'd0;
    logic [2:0] ent_rtype = 3'd3;
    logic ent_brk = 1'b0;
    logic ent_dirty = 1'b1;
    logic ent_trap = 1'b0;
    logic res_valid;
    logic [2:0] res_rights;
    logic [3:0] res_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prot_check_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
        .priv(priv), .xlate_en(xlate_en), .pid_chk_en(pid_chk_en),
        .pid_regs(pid_regs), .ent_valid(ent_valid), .ent_aid(ent_aid),
        .ent_rd_pl(ent_rd_pl), .ent_wr_pl(ent_wr_pl), .ent_rtype(ent_rtype),
        .ent_brk(ent_brk), .ent_dirty(ent_dirty), .ent_trap(ent_trap),
        .res_valid(res_valid), .res_rights(res_rights), .res_fault(res_fault)
    );

    task automatic check(string req, logic [2:0] er, logic [3:0] ef, logic ev);
        checks++;
        if (res_rights !== er || res_fault !== ef || res_valid !== ev) begin
            errors++;
            $display("FAIL %s: valid/rights/fault got %0b/%03b/%0d expected %0b/%03b/%0d",
                     req, res_valid, res_rights, res_fault, ev, er, ef);
        end
    endtask

    // Full-rights entry at privilege 0, identifier checking off.
    task automatic base_entry();
        xlate_en = 1'b1; ent_valid = 1'b1; pid_chk_en = 1'b0; pid_regs = '0;
        ent_aid = '0; ent_rd_pl = 2'd3; ent_wr_pl = 2'd0; ent_rtype = 3'd3;
        ent_brk = 1'b0; ent_dirty = 1'b1; ent_trap = 1'b0; priv = 2'd0;
    endtask

    // Issue one request and check the registered result one edge later.
    task automatic issue(string req, logic [1:0] kind, logic [2:0] er, logic [3:0] ef);
        acc_kind = kind;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(req, er, ef, 1'b1);
    endtask

    task automatic t_reset();
        check("R11 reset", 3'b000, 4'd0, 1'b0);
    endtask

    task automatic t_bypass();
        base_entry();
        xlate_en = 1'b0; ent_valid = 1'b0; ent_rtype = 3'd0; ent_trap = 1'b1;
        issue("R1 bypass write", 2'd2, 3'b111, 4'd0);
    endtask

    task automatic t_miss();
        base_entry();
        ent_valid = 1'b0;
        issue("R2 miss exec", 2'd3, 3'b000, 4'd1);
        issue("R2 miss read", 2'd1, 3'b000, 4'd2);
        issue("R2 miss none", 2'd0, 3'b000, 4'd2);
    endtask

    task automatic t_priv_types();
        base_entry();
        ent_rd_pl = 2'd2; ent_wr_pl = 2'd1;
        priv = 2'd1; issue("R3 all granted", 2'd1, 3'b111, 4'd0);
        priv = 2'd2; issue("R3 write denied", 2'd2, 3'b101, 4'd5);
        priv = 2'd3; issue("R3 exec above bound", 2'd3, 3'b000, 4'd4);
        base_entry();
        ent_rtype = 3'd0; issue("R4 type0 write", 2'd2, 3'b001, 4'd5);
        ent_rtype = 3'd1; issue("R4 type1 write", 2'd2, 3'b011, 4'd0);
        ent_rtype = 3'd2; issue("R4 type2 exec", 2'd3, 3'b101, 4'd0);
        ent_rtype = 3'd5; ent_rd_pl = 2'd2; priv = 2'd1;
        issue("R6 type5 read", 2'd1, 3'b100, 4'd5);
        issue("R4 type5 exec", 2'd3, 3'b100, 4'd0);
    endtask

    task automatic t_pid();
        base_entry();
        pid_chk_en = 1'b1; ent_aid = 15'd5;
        pid_regs[2*PID_W +: PID_W] = 16'd11;
        ent_dirty = 1'b0;
        issue("R5 match write", 2'd2, 3'b101, 4'd3);
        ent_dirty = 1'b1;
        issue("R5 match read", 2'd1, 3'b101, 4'd0);
        pid_regs[2*PID_W +: PID_W] = 16'd10;
        issue("R5 even value no match", 2'd2, 3'b111, 4'd0);
        pid_regs[2*PID_W +: PID_W] = 16'd11; pid_chk_en = 1'b0;
        issue("R5 check disabled", 2'd2, 3'b111, 4'd0);
        pid_chk_en = 1'b1; ent_aid = '0; pid_regs[0 +: PID_W] = 16'd1;
        issue("R5 public id", 2'd2, 3'b111, 4'd0);
    endtask

    task automatic t_probe();
        base_entry();
        ent_rtype = 3'd0; ent_rd_pl = 2'd0; priv = 2'd3;
        issue("R10 probe no rights", 2'd0, 3'b000, 4'd0);
        base_entry();
        ent_dirty = 1'b0; ent_trap = 1'b1; ent_brk = 1'b1;
        issue("R10 probe skips bits", 2'd0, 3'b111, 4'd0);
        pid_chk_en = 1'b1; ent_aid = 15'd2; pid_regs[3*PID_W +: PID_W] = 16'd5;
        issue("R10 probe after pid", 2'd0, 3'b101, 4'd0);
    endtask

    task automatic t_bits();
        base_entry();
        ent_dirty = 1'b0;
        issue("R7 dirty write", 2'd2, 3'b101, 4'd6);
        issue("R7 dirty read", 2'd1, 3'b101, 4'd0);
        ent_brk = 1'b1;
        issue("R8 break over dirty", 2'd2, 3'b101, 4'd7);
        ent_dirty = 1'b1;
        issue("R8 break write", 2'd2, 3'b101, 4'd7);
        ent_trap = 1'b1; ent_dirty = 1'b0;
        issue("R9 trap over all", 2'd2, 3'b100, 4'd8);
        ent_brk = 1'b0; ent_dirty = 1'b1;
        issue("R9 trap read", 2'd1, 3'b100, 4'd8);
        issue("R9 trap exec", 2'd3, 3'b100, 4'd0);
    endtask

    task automatic t_hold();
        @(posedge clk); #1;
        check("R11 idle hold", 3'b100, 4'd0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_bypass();
        t_miss();
        t_priv_types();
        t_pid();
        t_probe();
        t_bits();
        t_hold();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run incomplete, got timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule